// File: doc/BRIEF.md
# GPIO Interrupt Condition Detector

This block watches a set of general-purpose input pins and turns a configured condition on each pin into a latched status bit and an interrupt request. Each pin passes through its own synchronizer. A per-pin configuration then selects what counts as an event on that pin:

- a level, either high or low;
- a rising edge;
- a falling edge;
- both edges.

The detection code is either two bits or one bit wide, and the choice is made at elaboration. With the one-bit code, catching both edges means changing the polarity input after each event.

Each pin has an enable and an arm-only control. Either one lets the sticky status bit latch, but only the enable forwards the status as a request. An acknowledge clears the status bit. A parameter fixes whether the acknowledge data value 1 or 0 performs the clear. A registered summary ORs the requests of all pins. A routed copy of that summary is also produced: each pin carries a 3-bit destination field, and its request is steered to the matching destination line.

Top module: `gpirq_detector`

## Requirements
- R1: While reset is held and on the first cycle after it, irq_sts, irq_req, irq_any and irq_dest are all zero.
- R2: With DET_W=2, the code selects the condition: 0 = level, 1 = rising edge, 2 = falling edge, 3 = both edges. An edge sets status once per transition, and a steady input after an acknowledge sets nothing more. An edge mode ignores the opposite edge.
- R3: In level mode, cfg_pol=1 selects a high level and cfg_pol=0 selects a low level. The status bit stays set while the level is present, and an acknowledge has no effect then. Once the level is gone, the status stays set until it is acknowledged.
- R4: With DET_W=1, code 1 means edge and code 0 means level. For an edge, cfg_pol=1 selects rising and cfg_pol=0 selects falling. Changing cfg_pol after an event lets the opposite edge be caught.
- R5: With cfg_raw=1 and cfg_en=0, the status bit latches while irq_req stays low. irq_req[i] is high only when status and enable are both set.
- R6: With cfg_en=0 and cfg_raw=0, an input event leaves the status bit clear.
- R7: When ack_valid is set, the pin named by ack_pin is cleared if ack_data equals ACK_ONE. Any other ack_data value leaves that status bit unchanged.
- R8: irq_any equals the OR of irq_req from the previous clock.
- R9: irq_dest has a bit for each destination 0..7. Bit d is high one clock after a pin whose cfg_tgt equals d has its request high, and it is low otherwise. irq_any equals the OR of irq_dest.
- R10: A change on pin_in reaches irq_sts after SYNC_STAGES+1 clock edges. With the default of 2 stages, that is the third edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | NUM_PINS | Asynchronous pin inputs |
| cfg_en | input | NUM_PINS | Per-pin forward enable |
| cfg_raw | input | NUM_PINS | Per-pin latch-while-disabled control |
| cfg_pol | input | NUM_PINS | Per-pin polarity |
| cfg_det | input | NUM_PINS*DET_W | Per-pin detection code, pin i at bits i*DET_W |
| cfg_tgt | input | NUM_PINS*TGT_W | Per-pin destination index, pin i at bits i*TGT_W |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_pin | input | IDX_W | Pin addressed by the acknowledge |
| ack_data | input | 1 | Acknowledge data bit |
| irq_sts | output | NUM_PINS | Sticky status per pin |
| irq_req | output | NUM_PINS | Request per pin |
| irq_any | output | 1 | Registered OR of all requests |
| irq_dest | output | 2**TGT_W | Registered requests routed per destination |

## Verification
The bench builds two copies of the block side by side. The first uses DET_W=2 and ACK_ONE=1, which reaches the four two-bit detection codes, both level polarities and clear-on-one acknowledges. The second uses DET_W=1 and ACK_ONE=0, which reaches the single-bit edge/level form, catching both edges by flipping the polarity, and the inverted acknowledge value that must be ignored. Both copies keep four pins and eight destinations, so that several pins share one destination line and others sit on separate lines.

// File: rtl/gpirq_pkg.sv
package gpirq_pkg;
   // two-bit detection codes
   typedef enum logic [1:0] {
      DET2_LEVEL = 2'd0,
      DET2_RISE  = 2'd1,
      DET2_FALL  = 2'd2,
      DET2_BOTH  = 2'd3
   } det2_e;

   // one-bit detection codes
   localparam logic DET1_LEVEL = 1'b0;
   localparam logic DET1_EDGE  = 1'b1;

   function automatic logic level_match(input logic smp, input logic pol);
      return smp == pol;
   endfunction
endpackage

// File: rtl/gpirq_sync.sv
module gpirq_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) stg[k] <= '0;
      end else begin
         stg[0] <= d;
         for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/gpirq_pin.sv
module gpirq_pin
   import gpirq_pkg::*;
#(
   parameter int DET_W   = 2,
   parameter bit ACK_ONE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             smp,
   input  logic             en,
   input  logic             raw,
   input  logic             pol,
   input  logic [DET_W-1:0] det,
   input  logic             ack_wr,
   input  logic             ack_val,
   output logic             sts,
   output logic             req
);
   logic prev_q;
   logic rise, fall, lvl, hit, clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= smp;
   end

   assign rise = smp & ~prev_q;
   assign fall = ~smp & prev_q;
   assign lvl  = level_match(smp, pol);

   generate
      if (DET_W == 2) begin : g_det2
         always_comb begin
            unique case (det2_e'(det))
               DET2_LEVEL: hit = lvl;
               DET2_RISE:  hit = rise;
               DET2_FALL:  hit = fall;
               default:    hit = rise | fall;
            endcase
         end
      end else begin : g_det1
         always_comb begin
            if (det[0] == DET1_EDGE) hit = pol ? rise : fall;
            else                     hit = lvl;
         end
      end
   endgenerate

   assign clr = ack_wr && (ack_val == ACK_ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  sts <= 1'b0;
      else if (hit && (en || raw)) sts <= 1'b1;
      else if (clr)                sts <= 1'b0;
   end

   assign req = sts & en;
endmodule

// File: rtl/gpirq_merge.sv
module gpirq_merge #(
   parameter int NUM_PINS = 4,
   parameter int TGT_W    = 3
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_PINS-1:0]       req,
   input  logic [NUM_PINS*TGT_W-1:0] tgt,
   output logic                      any,
   output logic [(1<<TGT_W)-1:0]     dest
);
   localparam int NUM_DEST = 1 << TGT_W;

   logic                any_n;
   logic [NUM_DEST-1:0] dest_n;

   always_comb begin
      any_n  = 1'b0;
      dest_n = '0;
      for (int i = 0; i < NUM_PINS; i++) begin
         any_n = any_n | req[i];
         if (req[i]) dest_n[tgt[i*TGT_W +: TGT_W]] = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         any  <= 1'b0;
         dest <= '0;
      end else begin
         any  <= any_n;
         dest <= dest_n;
      end
   end
endmodule

// File: rtl/gpirq_detector.sv
module gpirq_detector #(
   parameter int NUM_PINS    = 4,
   parameter int DET_W       = 2,
   parameter int TGT_W       = 3,
   parameter int SYNC_STAGES = 2,
   parameter bit ACK_ONE     = 1'b1,
   parameter int IDX_W       = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_PINS-1:0]       pin_in,
   input  logic [NUM_PINS-1:0]       cfg_en,
   input  logic [NUM_PINS-1:0]       cfg_raw,
   input  logic [NUM_PINS-1:0]       cfg_pol,
   input  logic [NUM_PINS*DET_W-1:0] cfg_det,
   input  logic [NUM_PINS*TGT_W-1:0] cfg_tgt,
   input  logic                      ack_valid,
   input  logic [IDX_W-1:0]          ack_pin,
   input  logic                      ack_data,
   output logic [NUM_PINS-1:0]       irq_sts,
   output logic [NUM_PINS-1:0]       irq_req,
   output logic                      irq_any,
   output logic [(1<<TGT_W)-1:0]     irq_dest
);
   generate
      if (DET_W != 1 && DET_W != 2) begin : g_bad_det
         $error("DET_W must be 1 or 2");
      end
      if (NUM_PINS < 1) begin : g_bad_pins
         $error("NUM_PINS must be at least 1");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
      if ((1 << IDX_W) < NUM_PINS) begin : g_bad_idx
         $error("IDX_W too narrow for NUM_PINS");
      end
   endgenerate

   logic [NUM_PINS-1:0] smp;

   gpirq_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (smp)
   );

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      gpirq_pin #(.DET_W(DET_W), .ACK_ONE(ACK_ONE)) u_pin (
         .clk     (clk),
         .rst_n   (rst_n),
         .smp     (smp[i]),
         .en      (cfg_en[i]),
         .raw     (cfg_raw[i]),
         .pol     (cfg_pol[i]),
         .det     (cfg_det[i*DET_W +: DET_W]),
         .ack_wr  (ack_valid && (ack_pin == IDX_W'(i))),
         .ack_val (ack_data),
         .sts     (irq_sts[i]),
         .req     (irq_req[i])
      );
   end

   gpirq_merge #(.NUM_PINS(NUM_PINS), .TGT_W(TGT_W)) u_merge (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (irq_req),
      .tgt   (cfg_tgt),
      .any   (irq_any),
      .dest  (irq_dest)
   );
endmodule

// File: rtl/gpirq_detector_chk.sv
module gpirq_detector_chk #(
   parameter int NUM_PINS = 4,
   parameter int TGT_W    = 3,
   parameter int IDX_W    = 2,
   parameter bit ACK_ONE  = 1'b1
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [NUM_PINS-1:0]   cfg_en,
   input logic [NUM_PINS-1:0]   cfg_raw,
   input logic                  ack_valid,
   input logic [IDX_W-1:0]      ack_pin,
   input logic                  ack_data,
   input logic [NUM_PINS-1:0]   irq_sts,
   input logic [NUM_PINS-1:0]   irq_req,
   input logic                  irq_any,
   input logic [(1<<TGT_W)-1:0] irq_dest
);
   for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
      // R5, R6: status latches only when armed
      a_r5_set_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(irq_sts[i]) |-> $past(cfg_en[i] | cfg_raw[i]));

      // R7: status drops only through a matching acknowledge
      a_r7_clear_by_ack: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(irq_sts[i]) |->
            $past(ack_valid && (ack_pin == IDX_W'(i)) && (ack_data == ACK_ONE)));

      // R5: a request implies latched status
      a_r5_req_has_sts: assert property (@(posedge clk) disable iff (!rst_n)
         irq_req[i] |-> irq_sts[i]);
   end

   // R8: summary lags the requests by one clock
   a_r8_any_lag: assert property (@(posedge clk) disable iff (!rst_n)
      irq_any == $past(|irq_req));

   // R9: routed lines agree with the summary
   a_r9_dest_agrees: assert property (@(posedge clk) disable iff (!rst_n)
      irq_any == (|irq_dest));
endmodule

bind gpirq_detector gpirq_detector_chk #(
   .NUM_PINS (NUM_PINS),
   .TGT_W    (TGT_W),
   .IDX_W    (IDX_W),
   .ACK_ONE  (ACK_ONE)
) u_chk (.*);

// File: tb/gpirq_detector_tb.sv
`timescale 1ns/1ps
module gpirq_detector_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   // instance A: two-bit detection, clear on one
   logic [3:0] pin_a = '0, en_a = '0, raw_a = '0, pol_a = '0;
   logic [7:0] det_a = '0;
   logic [11:0] tgt_a = '0;
   logic ackv_a = 1'b0, ackd_a = 1'b0;
   logic [1:0] ackp_a = '0;
   logic [3:0] sts_a, req_a;
   logic any_a;
   logic [7:0] dest_a;

   // instance B: one-bit detection, clear on zero
   logic [3:0] pin_b = '0, en_b = '0, raw_b = '0, pol_b = '0;
   logic [3:0] det_b = '0;
   logic [11:0] tgt_b = '0;
   logic ackv_b = 1'b0, ackd_b = 1'b0;
   logic [1:0] ackp_b = '0;
   logic [3:0] sts_b, req_b;
   logic any_b;
   logic [7:0] dest_b;

   gpirq_detector #(.NUM_PINS(4), .DET_W(2), .TGT_W(3), .SYNC_STAGES(2), .ACK_ONE(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_a), .cfg_en(en_a), .cfg_raw(raw_a),
      .cfg_pol(pol_a), .cfg_det(det_a), .cfg_tgt(tgt_a), .ack_valid(ackv_a),
      .ack_pin(ackp_a), .ack_data(ackd_a), .irq_sts(sts_a), .irq_req(req_a),
      .irq_any(any_a), .irq_dest(dest_a));

   gpirq_detector #(.NUM_PINS(4), .DET_W(1), .TGT_W(3), .SYNC_STAGES(2), .ACK_ONE(1'b0)) u_dut_w1 (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_b), .cfg_en(en_b), .cfg_raw(raw_b),
      .cfg_pol(pol_b), .cfg_det(det_b), .cfg_tgt(tgt_b), .ack_valid(ackv_b),
      .ack_pin(ackp_b), .ack_data(ackd_b), .irq_sts(sts_b), .irq_req(req_b),
      .irq_any(any_b), .irq_dest(dest_b));

   typedef struct {
      int         dut;
      string      rid;
      logic [3:0] sts;
      logic [3:0] req;
      logic       any;
      logic [7:0] dest;
   } exp_t;

   exp_t sb[$];
   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic expect_st(input int dut, input string rid, input logic [3:0] s,
                            input logic [3:0] r, input logic a, input logic [7:0] d);
      exp_t e;
      e.dut = dut; e.rid = rid; e.sts = s; e.req = r; e.any = a; e.dest = d;
      sb.push_back(e);
      @(negedge clk);
      #0.1;
   endtask

   task automatic ack_a(input int pin, input logic val);
      ackv_a = 1'b1; ackp_a = 2'(pin); ackd_a = val;
      step(1);
      ackv_a = 1'b0;
      step(2);
   endtask

   task automatic ack_b(input int pin, input logic val);
      ackv_b = 1'b1; ackp_b = 2'(pin); ackd_b = val;
      step(1);
      ackv_b = 1'b0;
      step(2);
   endtask

   // monitor: pop expectations and compare at the falling edge
   always @(negedge clk) begin
      while (sb.size() > 0) begin
         exp_t e;
         logic [3:0] gs, gr;
         logic ga;
         logic [7:0] gd;
         e = sb.pop_front();
         if (e.dut == 0) begin gs = sts_a; gr = req_a; ga = any_a; gd = dest_a; end
         else            begin gs = sts_b; gr = req_b; ga = any_b; gd = dest_b; end
         checks++;
         if (gs !== e.sts || gr !== e.req || ga !== e.any || gd !== e.dest) begin
            fails++;
            $display("FAIL %s dut%0d: got sts=%b req=%b any=%b dest=%h exp sts=%b req=%b any=%b dest=%h",
                     e.rid, e.dut, gs, gr, ga, gd, e.sts, e.req, e.any, e.dest);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: got timeout exp completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      // A: pin0 rise tgt2, pin1 fall tgt5, pin2 both (raw only) tgt0, pin3 level high tgt5
      det_a = {2'd0, 2'd3, 2'd2, 2'd1};
      en_a  = 4'b1011;
      raw_a = 4'b0100;
      pol_a = 4'b1000;
      tgt_a = {3'd5, 3'd0, 3'd5, 3'd2};
      step(3);
      rst_n = 1'b1;
      step(1);
      expect_st(0, "R1 reset A", 4'b0000, 4'b0000, 1'b0, 8'h00);
      expect_st(1, "R1 reset B", 4'b0000, 4'b0000, 1'b0, 8'h00);

      // R10 latency, R8 summary lag, R9 routing
      pin_a[0] = 1'b1;
      step(2);
      expect_st(0, "R10 not yet", 4'b0000, 4'b0000, 1'b0, 8'h00);
      step(1);
      expect_st(0, "R10 third edge", 4'b0001, 4'b0001, 1'b0, 8'h00);
      step(1);
      expect_st(0, "R8 R9 summary", 4'b0001, 4'b0001, 1'b1, 8'h04);
      step(5);
      ack_a(0, 1'b1);
      expect_st(0, "R2 one event per edge", 4'b0000, 4'b0000, 1'b0, 8'h00);
      pin_a[0] = 1'b0;
      step(4);
      expect_st(0, "R2 rise ignores fall", 4'b0000, 4'b0000, 1'b0, 8'h00);
      pin_a[1] = 1'b1;
      step(4);
      expect_st(0, "R2 fall ignores rise", 4'b0000, 4'b0000, 1'b0, 8'h00);
      pin_a[1] = 1'b0;
      step(4);
      expect_st(0, "R2 falling edge", 4'b0010, 4'b0010, 1'b1, 8'h20);
      pin_a[2] = 1'b1;
      step(4);
      expect_st(0, "R5 raw latches no req", 4'b0110, 4'b0010, 1'b1, 8'h20);
      ack_a(1, 1'b0);
      expect_st(0, "R7 wrong ack value", 4'b0110, 4'b0010, 1'b1, 8'h20);
      ack_a(2, 1'b1);
      expect_st(0, "R7 ack clears pin2", 4'b0010, 4'b0010, 1'b1, 8'h20);
      pin_a[2] = 1'b0;
      step(4);
      expect_st(0, "R2 both edges fall", 4'b0110, 4'b0010, 1'b1, 8'h20);
      ack_a(1, 1'b1);
      ack_a(2, 1'b1);
      expect_st(0, "R7 all cleared", 4'b0000, 4'b0000, 1'b0, 8'h00);
      raw_a[2] = 1'b0;
      pin_a[2] = 1'b1;
      step(4);
      expect_st(0, "R6 unarmed ignored", 4'b0000, 4'b0000, 1'b0, 8'h00);

      // R3 level high
      pin_a[3] = 1'b1;
      step(4);
      expect_st(0, "R3 level high", 4'b1000, 4'b1000, 1'b1, 8'h20);
      ack_a(3, 1'b1);
      expect_st(0, "R3 ack while active", 4'b1000, 4'b1000, 1'b1, 8'h20);
      pin_a[3] = 1'b0;
      step(4);
      expect_st(0, "R3 sticky after level", 4'b1000, 4'b1000, 1'b1, 8'h20);
      ack_a(3, 1'b1);
      expect_st(0, "R3 ack after level", 4'b0000, 4'b0000, 1'b0, 8'h00);
      pol_a[3] = 1'b0;
      step(4);
      expect_st(0, "R3 level low", 4'b1000, 4'b1000, 1'b1, 8'h20);
      pin_a[3] = 1'b1;
      step(4);
      ack_a(3, 1'b1);
      expect_st(0, "R3 low level gone", 4'b0000, 4'b0000, 1'b0, 8'h00);

      // B: one-bit detection
      en_b[0] = 1'b1; det_b[0] = 1'b1; pol_b[0] = 1'b1; tgt_b[2:0] = 3'd7;
      pin_b[0] = 1'b1;
      step(4);
      expect_st(1, "R4 edge rising", 4'b0001, 4'b0001, 1'b1, 8'h80);
      ack_b(0, 1'b1);
      expect_st(1, "R7 ack one ignored", 4'b0001, 4'b0001, 1'b1, 8'h80);
      ack_b(0, 1'b0);
      expect_st(1, "R7 ack zero clears", 4'b0000, 4'b0000, 1'b0, 8'h00);
      pol_b[0] = 1'b0;
      step(2);
      pin_b[0] = 1'b0;
      step(4);
      expect_st(1, "R4 flipped polarity falling", 4'b0001, 4'b0001, 1'b1, 8'h80);
      ack_b(0, 1'b0);
      expect_st(1, "R4 cleared", 4'b0000, 4'b0000, 1'b0, 8'h00);
      en_b[1] = 1'b1; det_b[1] = 1'b0; pol_b[1] = 1'b1; tgt_b[5:3] = 3'd3;
      step(2);
      expect_st(1, "R4 level idle", 4'b0000, 4'b0000, 1'b0, 8'h00);
      pin_b[1] = 1'b1;
      step(4);
      expect_st(1, "R4 level high", 4'b0010, 4'b0010, 1'b1, 8'h08);
      pin_b[1] = 1'b0;
      step(4);
      ack_b(1, 1'b0);
      expect_st(1, "R4 level cleared", 4'b0000, 4'b0000, 1'b0, 8'h00);

      step(2);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule